// File: doc/BRIEF.md
# Fixed-Latency Multiply/Divide Coprocessor

This unit sits next to a 16-bit ALU and carries out two long operations on its own: a 16x16-bit multiply that yields a 32-bit product, and a division of a 32-bit dividend by a 16-bit divisor that yields a 16-bit quotient and a 16-bit remainder. Both operations come in unsigned and two's-complement signed forms. The unit does not form a product or a quotient in a single combinational step. It works through the operand a few bits per clock, then applies the sign in a final cycle.

A one-cycle start strobe, sampled while the unit is idle, captures the operation code and the operands. Busy then stays high until a one-cycle done pulse. Every multiply takes exactly 5 cycles and every divide exactly 10, whatever the operand values, so software can count cycles and does not need to poll. The answer is written to a high and a low 16-bit result register, which keep their value until the next operation that finishes without error. Two flags report a zero divisor and a quotient that does not fit in 16 bits.

Top module: `mulDivUnit`

## Requirements
- R1: With opSel = 2'b00 (unsigned multiply), resHi holds bits 31:16 and resLo holds bits 15:0 of srcA[15:0] times srcB. Done is high in the cycle that follows the 5th rising edge after the edge that accepted start.
- R2: With opSel = 2'b01 (signed multiply), both 16-bit operands are two's complement and {resHi,resLo} holds the 32-bit two's-complement product. Timing is the same as R1.
- R3: With opSel = 2'b10 (unsigned divide), resLo holds srcA / srcB and resHi holds srcA mod srcB. Done is high in the cycle that follows the 10th rising edge after the accepting edge.
- R4: With opSel = 2'b11 (signed divide), the 32-bit dividend and the 16-bit divisor are two's complement. The quotient is truncated toward zero and the remainder takes the sign of the dividend. Timing is the same as R3.
- R5: A divide whose divisor is zero sets divZero and clears divOvf at completion, and leaves resHi and resLo unchanged.
- R6: A divide with a nonzero divisor whose quotient falls outside 0..65535 (unsigned) or outside -32768..32767 (signed) sets divOvf and clears divZero at completion, and leaves resHi and resLo unchanged.
- R7: Busy rises on the edge that accepts start and stays high until the edge that raises done. Done lasts one cycle, and busy is low while done is high.
- R8: A start that arrives while busy is high has no effect on the latency, the results or the flags of the operation in flight.
- R9: After reset, busy, done, divZero and divOvf are 0 and resHi and resLo are 0.
- R10: Every operation that completes without error, whether a multiply or a divide, clears both divZero and divOvf.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while busy is low |
| opSel | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| srcA | input | 32 | Dividend; a multiply uses only bits 15:0 |
| srcB | input | 16 | Multiplier or divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| resHi | output | 16 | Product bits 31:16, or remainder |
| resLo | output | 16 | Product bits 15:0, or quotient |
| divZero | output | 1 | Last divide had a zero divisor |
| divOvf | output | 1 | Last divide's quotient did not fit |

## Verification
The results and the flags change together, on the 5th rising edge after the accepting edge for a multiply and on the 10th for a divide. Done rises on that same edge and busy falls on it. The bench keeps its own model of the unit that counts down the same number of edges from each start it accepts, and updates its expected busy, done, results and flags on that edge. It compares all six outputs against that model at every falling clock edge, half a period after the design's registers have settled. A start issued during an operation is checked simply by comparing every cycle: the model ignores it, so the design must finish at the original time with the original answer.

// File: rtl/mduPkg.sv
package mduPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands and operation
    logic step;    // perform one iteration
    logic finish;  // apply sign and write results or flags
  } mduCtl_t;

  // opSel encoding: bit 1 selects divide, bit 0 selects signed
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mduOp_t;

endpackage

// File: rtl/mduControl.sv
module mduControl
  import mduPkg::*;
#(
  parameter int W        = 16,
  parameter int MUL_BITS = 4,
  parameter int DIV_BITS = 2,
  parameter int LAT_MUL  = 5,
  parameter int LAT_DIV  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSel,
  output mduCtl_t    ctl,
  output logic       busy,
  output logic       done
);

  localparam int MUL_STEPS = W / MUL_BITS;
  localparam int DIV_STEPS = W / DIV_BITS;
  localparam int CNT_W     = $clog2(LAT_DIV + 1) + 1;

  logic [CNT_W-1:0] cyclesLeft;
  logic [CNT_W-1:0] stepsLeft;
  logic [CNT_W-1:0] latSel;
  logic [CNT_W-1:0] stepSel;

  always_comb begin
    latSel  = opSel[1] ? CNT_W'(LAT_DIV)   : CNT_W'(LAT_MUL);
    stepSel = opSel[1] ? CNT_W'(DIV_STEPS) : CNT_W'(MUL_STEPS);
  end

  always_comb begin
    ctl.load   = start && !busy;
    ctl.step   = busy && (stepsLeft != '0);
    ctl.finish = busy && (cyclesLeft == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      cyclesLeft <= '0;
      stepsLeft  <= '0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        busy       <= 1'b1;
        cyclesLeft <= latSel;
        stepsLeft  <= stepSel;
      end else if (busy) begin
        if (ctl.finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        cyclesLeft <= cyclesLeft - CNT_W'(1);
        if (stepsLeft != '0) stepsLeft <= stepsLeft - CNT_W'(1);
      end
    end
  end

  // Latency watch: counts edges from acceptance, independent of cyclesLeft
  logic [CNT_W-1:0] sinceStart;
  logic             watchDiv;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= '0;
      watchDiv   <= 1'b0;
    end else if (start && !busy) begin
      sinceStart <= '0;
      watchDiv   <= opSel[1];
    end else if (busy) begin
      sinceStart <= sinceStart + CNT_W'(1);
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sinceStart == (watchDiv ? CNT_W'(LAT_DIV) : CNT_W'(LAT_MUL)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_low_on_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> $stable(watchDiv));

  initial begin
    assert (LAT_MUL > MUL_STEPS && LAT_DIV > DIV_STEPS);
    assert (W % MUL_BITS == 0 && W % DIV_BITS == 0);
  end

endmodule

// File: rtl/mduDatapath.sv
module mduDatapath
  import mduPkg::*;
#(
  parameter int W        = 16,
  parameter int MUL_BITS = 4,
  parameter int DIV_BITS = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  mduCtl_t        ctl,
  input  logic [1:0]     opSel,
  input  logic [2*W-1:0] srcA,
  input  logic [W-1:0]   srcB,
  output logic [W-1:0]   resHi,
  output logic [W-1:0]   resLo,
  output logic           divZero,
  output logic           divOvf
);

  localparam int DW = 2 * W;
  localparam int SW = W + MUL_BITS;
  localparam logic [W-1:0] HALF = W'(1) << (W - 1);

  // Captured operation state
  logic         isDiv, isSigned, negQ, negR, preOvf, zeroDiv;
  logic [W-1:0] opnd;     // multiplicand or divisor magnitude
  logic [W-1:0] hiReg;    // product high accumulator, or partial remainder
  logic [W-1:0] loReg;    // multiplier shifting out, or dividend/quotient

  // Operand magnitudes at load
  logic          sgnIn;
  logic [W-1:0]  mulAMag, bMag;
  logic [DW-1:0] dvdMag;

  always_comb begin
    sgnIn   = opSel[0];
    mulAMag = (sgnIn && srcA[W-1])  ? W'(-srcA[W-1:0]) : srcA[W-1:0];
    bMag    = (sgnIn && srcB[W-1])  ? W'(-srcB)        : srcB;
    dvdMag  = (sgnIn && srcA[DW-1]) ? DW'(-srcA)       : srcA;
  end

  // One multiply iteration: MUL_BITS multiplier bits per step
  logic [SW-1:0] mulSum;
  logic [W-1:0]  mulHiNext, mulLoNext;

  always_comb begin
    mulSum    = SW'(hiReg) + SW'(loReg[MUL_BITS-1:0]) * SW'(opnd);
    mulHiNext = mulSum[SW-1:MUL_BITS];
    mulLoNext = {mulSum[MUL_BITS-1:0], loReg[W-1:MUL_BITS]};
  end

  // One divide iteration: DIV_BITS restoring steps per cycle
  logic [W:0]   shiftRem;
  logic [W-1:0] divRemNext, divQuoNext;

  always_comb begin
    divRemNext = hiReg;
    divQuoNext = loReg;
    shiftRem   = '0;
    for (int i = 0; i < DIV_BITS; i++) begin
      shiftRem   = {divRemNext, divQuoNext[W-1]};
      divQuoNext = {divQuoNext[W-2:0], 1'b0};
      if (shiftRem >= {1'b0, opnd}) begin
        shiftRem      = shiftRem - {1'b0, opnd};
        divQuoNext[0] = 1'b1;
      end
      divRemNext = shiftRem[W-1:0];
    end
  end

  // Final sign handling
  logic [DW-1:0] prodSigned;
  logic [W-1:0]  quoSigned, remSigned;
  logic          quoRange;

  always_comb begin
    prodSigned = negQ ? DW'(-{hiReg, loReg}) : {hiReg, loReg};
    quoSigned  = negQ ? W'(-loReg) : loReg;
    remSigned  = negR ? W'(-hiReg) : hiReg;
    quoRange   = isSigned && (negQ ? (loReg > HALF) : loReg[W-1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isDiv    <= 1'b0;
      isSigned <= 1'b0;
      negQ     <= 1'b0;
      negR     <= 1'b0;
      preOvf   <= 1'b0;
      zeroDiv  <= 1'b0;
      opnd     <= '0;
      hiReg    <= '0;
      loReg    <= '0;
    end else if (ctl.load) begin
      isDiv    <= opSel[1];
      isSigned <= sgnIn;
      if (opSel[1]) begin
        opnd    <= bMag;
        hiReg   <= dvdMag[DW-1:W];
        loReg   <= dvdMag[W-1:0];
        zeroDiv <= (bMag == '0);
        preOvf  <= (dvdMag[DW-1:W] >= bMag);
        negQ    <= sgnIn && (srcA[DW-1] ^ srcB[W-1]);
        negR    <= sgnIn && srcA[DW-1];
      end else begin
        opnd    <= mulAMag;
        hiReg   <= '0;
        loReg   <= bMag;
        zeroDiv <= 1'b0;
        preOvf  <= 1'b0;
        negQ    <= sgnIn && (srcA[W-1] ^ srcB[W-1]);
        negR    <= 1'b0;
      end
    end else if (ctl.step) begin
      hiReg <= isDiv ? divRemNext : mulHiNext;
      loReg <= isDiv ? divQuoNext : mulLoNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHi   <= '0;
      resLo   <= '0;
      divZero <= 1'b0;
      divOvf  <= 1'b0;
    end else if (ctl.finish) begin
      if (!isDiv) begin
        resHi   <= prodSigned[DW-1:W];
        resLo   <= prodSigned[W-1:0];
        divZero <= 1'b0;
        divOvf  <= 1'b0;
      end else if (zeroDiv) begin
        divZero <= 1'b1;
        divOvf  <= 1'b0;
      end else if (preOvf || quoRange) begin
        divZero <= 1'b0;
        divOvf  <= 1'b1;
      end else begin
        resHi   <= remSigned;
        resLo   <= quoSigned;
        divZero <= 1'b0;
        divOvf  <= 1'b0;
      end
    end
  end

  assert_zero_keeps_results_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && isDiv && zeroDiv) |=> ($stable({resHi, resLo}) && divZero));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && isDiv && !zeroDiv && preOvf) |=> ($stable({resHi, resLo}) && divOvf));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({divZero, divOvf}));

  assert_mul_clears_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !isDiv) |=> (!divZero && !divOvf));

  assert_regs_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable({hiReg, loReg, opnd}));

endmodule

// File: rtl/mulDivUnit.sv
module mulDivUnit
  import mduPkg::*;
#(
  parameter int W        = 16,
  parameter int MUL_BITS = 4,
  parameter int DIV_BITS = 2,
  parameter int LAT_MUL  = 5,
  parameter int LAT_DIV  = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [1:0]     opSel,
  input  logic [2*W-1:0] srcA,
  input  logic [W-1:0]   srcB,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   resHi,
  output logic [W-1:0]   resLo,
  output logic           divZero,
  output logic           divOvf
);

  mduCtl_t ctl;

  mduControl #(
    .W(W), .MUL_BITS(MUL_BITS), .DIV_BITS(DIV_BITS),
    .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) uControl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  mduDatapath #(
    .W(W), .MUL_BITS(MUL_BITS), .DIV_BITS(DIV_BITS)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opSel   (opSel),
    .srcA    (srcA),
    .srcB    (srcB),
    .resHi   (resHi),
    .resLo   (resLo),
    .divZero (divZero),
    .divOvf  (divOvf)
  );

endmodule

// File: tb/mulDivUnit_test.sv
`timescale 1ns/1ps
module mulDivUnit_test;

  localparam int LAT_MUL = 5;
  localparam int LAT_DIV = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] srcA = '0;
  logic [15:0] srcB = '0;
  logic        busy, done, divZero, divOvf;
  logic [15:0] resHi, resLo;

  always #2.5 clk = ~clk;

  mulDivUnit uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .resHi(resHi), .resLo(resLo), .divZero(divZero), .divOvf(divOvf)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit comparing = 1'b0;

  // Behavioural reference state
  bit          mBusy, mDone, eZ, eO;
  int          mLeft;
  logic [15:0] eHi, eLo;
  string       eTag = "R9";
  bit          pZ, pO, pWr;
  logic [15:0] pHi, pLo;
  string       pTag;

  task automatic calc(input logic [1:0] op, input logic [31:0] a, input logic [15:0] b);
    longint p, q, r, dd, dv;
    pZ = 0; pO = 0; pWr = 0;
    if (!op[1]) begin
      if (op[0]) begin
        p = longint'($signed(a[15:0])) * longint'($signed(b));
        pTag = "R2";
      end else begin
        p = longint'(a[15:0]) * longint'(b);
        pTag = "R1";
      end
      pHi = p[31:16]; pLo = p[15:0]; pWr = 1;
    end else begin
      pTag = op[0] ? "R4" : "R3";
      dd = op[0] ? longint'($signed(a)) : longint'(a);
      dv = op[0] ? longint'($signed(b)) : longint'(b);
      if (dv == 0) begin
        pZ = 1; pTag = "R5";
      end else begin
        q = dd / dv;
        r = dd % dv;
        if (op[0] ? (q > 32767 || q < -32768) : (q > 65535)) begin
          pO = 1; pTag = "R6";
        end else begin
          pHi = r[15:0]; pLo = q[15:0]; pWr = 1;
        end
      end
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mLeft = 0;
      eHi = '0; eLo = '0; eZ = 0; eO = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1;
          eZ = pZ; eO = pO;  // R10: an error-free completion clears both flags
          if (pWr) begin eHi = pHi; eLo = pLo; end
          eTag = pTag;
        end
      end else if (start) begin
        calc(opSel, srcA, srcB);
        mBusy = 1;
        mLeft = opSel[1] ? LAT_DIV : LAT_MUL;
      end
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (comparing) begin
      chk("R7", "busy", busy, mBusy);
      chk("R7", "done", done, mDone);
      chk(eTag, "resHi", resHi, eHi);
      chk(eTag, "resLo", resLo, eLo);
      chk("R5", "divZero", divZero, eZ);
      chk("R6", "divOvf", divOvf, eO);
    end
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [15:0] b);
    @(negedge clk);
    start = 1'b1; opSel = op; srcA = a; srcB = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [15:0] b);
    issue(op, a, b);
    repeat (LAT_DIV + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset busy/done/flags", {busy, done, divZero, divOvf}, 0);
    chk("R9", "reset results", {resHi, resLo}, 0);
    rstN = 1'b1;
    comparing = 1'b1;

    // R1: unsigned multiply
    runOp(2'b00, 32'h0000_FFFF, 16'hFFFF);
    runOp(2'b00, 32'd1234, 16'd5678);
    runOp(2'b00, 32'd0, 16'hABCD);
    // R2: signed multiply
    runOp(2'b01, 32'h0000_FFFF, 16'hFFFF);
    runOp(2'b01, 32'h0000_8000, 16'h8000);
    runOp(2'b01, 32'h0000_FFFD, 16'd7);
    runOp(2'b01, 32'h0000_7FFF, 16'h8000);
    // R3: unsigned divide
    runOp(2'b10, 32'd100000, 16'd7);
    runOp(2'b10, 32'hFFFE_0001, 16'hFFFF);
    runOp(2'b10, 32'd5, 16'd9);
    // R4: signed divide, remainder follows dividend sign
    runOp(2'b11, -32'sd100, 16'd7);
    runOp(2'b11, 32'd100, -16'sd7);
    runOp(2'b11, -32'sd100, -16'sd7);
    runOp(2'b11, 32'hFFFF_8000, 16'd1);
    // R5: zero divisor keeps results
    runOp(2'b10, 32'd1234, 16'd0);
    // R10: multiply after error clears flags
    runOp(2'b00, 32'd3, 16'd4);
    // R6: quotient overflow
    runOp(2'b10, 32'hFFFF_FFFF, 16'hFFFF);
    runOp(2'b11, 32'd32768, 16'd1);
    runOp(2'b11, 32'h8000_0000, 16'hFFFF);
    // R10: divide after error clears flags
    runOp(2'b11, -32'sd9, 16'd2);
    // R8: start while busy is ignored
    issue(2'b00, 32'd300, 16'd301);
    repeat (2) @(negedge clk);
    issue(2'b10, 32'd77, 16'd0);
    repeat (LAT_DIV + 2) @(negedge clk);
    issue(2'b11, 32'd1000, 16'd3);
    repeat (4) @(negedge clk);
    issue(2'b01, 32'd5, 16'd5);
    repeat (LAT_DIV + 2) @(negedge clk);

    comparing = 1'b0;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule